// File: doc/BRIEF.md
# Low-Power Clock Mode Controller

This block produces the clock enables of a small microcontroller from its main oscillator clock. A divider turns the oscillator clock into a one-cycle enable pulse at a programmable ratio. The same pulse gates the CPU, the watchdog and five peripheral clock groups. Software sets the ratio, a peripheral gating mask and an oscillator settle time through a byte-wide register write port with two registers.

There are two low-power modes. In stop mode the oscillator and every derived enable are halted. Stop is entered by a register write, and it ends on a hardware reset or on an interrupt that was already enabled and globally unmasked at the moment of entry. A settle interval follows before the CPU enable resumes. In wait mode the oscillator and divider keep running, but the CPU and watchdog enables are held low. Each peripheral group either keeps its enable or loses it, according to its mask bit. Wait is entered by a one-cycle request from the CPU and ends on an enabled interrupt request or on reset.

Top module: `pwr_clk_ctrl`

## Requirements
- R1: After reset the mode status is run (00), the oscillator is running, the divider select reads 3 (divide by 8) and the settle count is 16.
- R2: Register 0x6 bits [7:5] select the divider. Values 0..4 give ratios 1, 2, 4, 8 and 16, and values 5..7 give 16. In run mode the CPU, watchdog and every peripheral enable pulse once per ratio period, all in the same cycle.
- R3: A new divider select takes effect only at the end of the current period. Every interval between CPU enable pulses equals either the old ratio or the new ratio.
- R4: Writing register 0x7 with bit 0 set while in run mode enters stop. The status reads 10, the oscillator-running output is low, and every clock enable stays low.
- R5: Entering stop forces divider select bit 1 (register 0x6 bit 6) to 1. Select 0 becomes 2 and select 1 becomes 3.
- R6: Stop ends on an interrupt request only when the interrupt enable and the global interrupt flag were both 1 in the cycle in which stop was entered. A hardware reset always ends stop.
- R7: On an interrupt wake from stop, the block spends exactly S cycles with the status at 10, the oscillator running and all enables low, then returns to run. S is register 0x7 bits [7:1]. S = 0 returns to run directly.
- R8: A one-cycle wait request in run mode enters wait. The status reads 01, and the CPU and watchdog enables stay low.
- R9: In wait, peripheral group g keeps pulsing at the divider rate when register 0x6 bit g is 0 and is held low when that bit is 1 (g = 0..4).
- R10: Wait ends only on an interrupt request with its enable at 1. Run resumes with the divider setting that was in force before wait.
- R11: Register writes made while not in run mode are ignored. This includes the divider select and the stop bit.
- R12: A stop write and a wait request in the same run cycle enter stop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main oscillator clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 4 | Register write address (0x6 clock config, 0x7 power control) |
| reg_wr_data | input | 8 | Register write data |
| wait_req | input | 1 | One-cycle pulse: CPU executed a wait instruction |
| irq_req | input | 1 | Interrupt request from the interrupt controller |
| irq_en | input | 1 | Enable of the requesting interrupt |
| gie | input | 1 | Global interrupt flag |
| cpu_clk_en | output | 1 | CPU clock enable pulse |
| wdt_clk_en | output | 1 | Watchdog clock enable pulse |
| per_clk_en | output | 5 | Peripheral group clock enable pulses |
| osc_run | output | 1 | Oscillator running (low only in stop) |
| mode_status | output | 2 | 00 run, 01 wait, 10 stop or settling |
| div_sel_o | output | 3 | Programmed divider select |

## Verification
The bench measures the enable rate over windows that are whole multiples of every ratio, for all eight select codes and for all 32 peripheral masks during wait. A divider with an off-by-one limit, or a gate that ignores its mask bit, shows up as a wrong pulse count. It times the intervals across select changes in both directions. A divider that switches at once produces a short or a wrapped interval there. Stop is entered with the interrupt qualifiers cleared and then set afterwards, which catches a design that samples them live rather than at entry. The settle interval is counted for S = 5, S = 0 and the default 16, which exposes an off-by-one in the warm-up counter. The bench also checks that select values 0 and 1 are forced on stop entry, and that writes made during wait leave the setting unchanged when wait ends.

// File: rtl/pcm_pkg.sv
// Package: shared types and helpers for the power/clock mode controller.
// Assumes a two-bit internal state and a two-bit externally visible status.
package pcm_pkg;

    typedef enum logic [1:0] {
        ST_RUN  = 2'b00,
        ST_WAIT = 2'b01,
        ST_STOP = 2'b10,
        ST_WARM = 2'b11
    } pcm_state_e;

    localparam logic [1:0] STATUS_RUN  = 2'b00;
    localparam logic [1:0] STATUS_WAIT = 2'b01;
    localparam logic [1:0] STATUS_STOP = 2'b10;

    // Map the internal state to the reported status; warm-up reports as stop.
    function automatic logic [1:0] status_of(input pcm_state_e s);
        case (s)
            ST_RUN:  return STATUS_RUN;
            ST_WAIT: return STATUS_WAIT;
            default: return STATUS_STOP;
        endcase
    endfunction

endpackage

// File: rtl/pcm_regs.sv
// Module: pcm_regs
// Holds the clock configuration register (divider select, peripheral mask)
// and the power control register (settle count, stop command).
// Assumes writes are accepted only when wr_allow is high (run mode).
// The stop command forces select bit FORCE_IDX to 1 in the same cycle.
module pcm_regs #(
    parameter int ADDR_W     = 4,
    parameter int DATA_W     = 8,
    parameter int SEL_W      = 3,
    parameter int NPER       = 5,
    parameter int SETTLE_W   = 7,
    parameter int CFG_ADDR   = 6,
    parameter int CTL_ADDR   = 7,
    parameter int RST_SEL    = 3,
    parameter int RST_SETTLE = 16,
    parameter int FORCE_IDX  = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic                wr_allow,
    output logic [SEL_W-1:0]    div_sel,
    output logic [NPER-1:0]     per_mask,
    output logic [SETTLE_W-1:0] settle,
    output logic                stop_cmd
);

    localparam int SEL_LSB    = DATA_W - SEL_W;
    localparam int STOP_BIT   = 0;
    localparam int SETTLE_LSB = DATA_W - SETTLE_W;

    logic cfg_hit;
    logic ctl_hit;

    // Decode accepted writes to each register.
    always_comb begin
        cfg_hit  = wr_en && wr_allow && (wr_addr == ADDR_W'(CFG_ADDR));
        ctl_hit  = wr_en && wr_allow && (wr_addr == ADDR_W'(CTL_ADDR));
        stop_cmd = ctl_hit && wr_data[STOP_BIT];
    end

    // Register update, including the forced select bit on stop entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_sel  <= SEL_W'(RST_SEL);
            per_mask <= '0;
            settle   <= SETTLE_W'(RST_SETTLE);
        end else begin
            if (cfg_hit) begin
                div_sel  <= wr_data[SEL_LSB +: SEL_W];
                per_mask <= wr_data[NPER-1:0];
            end
            if (ctl_hit) begin
                settle <= wr_data[SETTLE_LSB +: SETTLE_W];
            end
            if (stop_cmd) begin
                div_sel[FORCE_IDX] <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/pcm_divider.sv
// Module: pcm_divider
// Counts oscillator cycles and emits a one-cycle tick at the end of each
// period of 2**sel cycles (sel clamped at MAX_LOG2). A new select is loaded
// only at a period boundary, or while hold is high, so no period is cut short.
// Assumes hold is high whenever the oscillator is stopped or settling.
module pcm_divider #(
    parameter int SEL_W    = 3,
    parameter int MAX_LOG2 = 4,
    parameter int RST_SEL  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic [SEL_W-1:0] sel_req,
    output logic             tick
);

    localparam int CNT_W = MAX_LOG2;

    logic [CNT_W-1:0] cnt;
    logic [SEL_W-1:0] act_sel;
    logic             last;

    // Terminal count for a select value: ratio minus one.
    function automatic logic [CNT_W-1:0] limit_of(input logic [SEL_W-1:0] s);
        logic [CNT_W:0] p;
        if (int'(s) >= MAX_LOG2) p = {1'b1, {CNT_W{1'b0}}};
        else                     p = (CNT_W+1)'(1) << s;
        return CNT_W'(p - 1'b1);
    endfunction

    // End-of-period detect and gated tick.
    always_comb begin
        last = (cnt == limit_of(act_sel));
        tick = last && !hold;
    end

    // Period counter; the active select changes only at a boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            act_sel <= SEL_W'(RST_SEL);
        end else if (hold) begin
            cnt     <= '0;
            act_sel <= sel_req;
        end else if (last) begin
            cnt     <= '0;
            act_sel <= sel_req;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/pcm_mode_fsm.sv
// Module: pcm_mode_fsm
// Sequences run, wait, stop and the post-stop warm-up. Interrupt
// qualifiers for stop wake-up are captured at stop entry. The stop command
// wins over a wait request in the same cycle.
// Assumes stop_cmd can only be high in run mode.
module pcm_mode_fsm
    import pcm_pkg::*;
#(
    parameter int SETTLE_W = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                stop_cmd,
    input  logic                wait_req,
    input  logic                irq_req,
    input  logic                irq_en,
    input  logic                gie,
    input  logic [SETTLE_W-1:0] settle,
    output pcm_state_e          state
);

    logic                en_cap;
    logic                gie_cap;
    logic [SETTLE_W-1:0] warm_cnt;
    logic                stop_wake;

    // Stop wake-up is qualified by the values captured at entry.
    always_comb stop_wake = irq_req && en_cap && gie_cap;

    // Mode transitions and warm-up countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_RUN;
            en_cap   <= 1'b0;
            gie_cap  <= 1'b0;
            warm_cnt <= '0;
        end else begin
            case (state)
                ST_RUN: begin
                    if (stop_cmd) begin
                        state   <= ST_STOP;
                        en_cap  <= irq_en;
                        gie_cap <= gie;
                    end else if (wait_req) begin
                        state <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (irq_req && irq_en) state <= ST_RUN;
                end
                ST_STOP: begin
                    if (stop_wake) begin
                        if (settle == '0) begin
                            state <= ST_RUN;
                        end else begin
                            state    <= ST_WARM;
                            warm_cnt <= settle - 1'b1;
                        end
                    end
                end
                default: begin
                    if (warm_cnt == '0) state <= ST_RUN;
                    else                warm_cnt <= warm_cnt - 1'b1;
                end
            endcase
        end
    end

endmodule

// File: rtl/pwr_clk_ctrl.sv
// Module: pwr_clk_ctrl (top)
// Ties the registers, divider and mode sequencer together and gates the
// divider tick onto the CPU, watchdog and per-group peripheral enables.
// Assumes one clock domain (the oscillator) and a synchronous reset.
module pwr_clk_ctrl
    import pcm_pkg::*;
#(
    parameter int ADDR_W     = 4,
    parameter int DATA_W     = 8,
    parameter int SEL_W      = 3,
    parameter int NPER       = 5,
    parameter int SETTLE_W   = 7,
    parameter int MAX_LOG2   = 4,
    parameter int CFG_ADDR   = 6,
    parameter int CTL_ADDR   = 7,
    parameter int RST_SEL    = 3,
    parameter int RST_SETTLE = 16,
    parameter int FORCE_IDX  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [ADDR_W-1:0] reg_wr_addr,
    input  logic [DATA_W-1:0] reg_wr_data,
    input  logic              wait_req,
    input  logic              irq_req,
    input  logic              irq_en,
    input  logic              gie,
    output logic              cpu_clk_en,
    output logic              wdt_clk_en,
    output logic [NPER-1:0]   per_clk_en,
    output logic              osc_run,
    output logic [1:0]        mode_status,
    output logic [SEL_W-1:0]  div_sel_o
);

    pcm_state_e          state;
    logic [SEL_W-1:0]    div_sel;
    logic [NPER-1:0]     per_mask;
    logic [SETTLE_W-1:0] settle;
    logic                stop_cmd;
    logic                tick;
    logic                in_run;
    logic                in_wait;
    logic                hold;

    pcm_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEL_W(SEL_W), .NPER(NPER),
        .SETTLE_W(SETTLE_W), .CFG_ADDR(CFG_ADDR), .CTL_ADDR(CTL_ADDR),
        .RST_SEL(RST_SEL), .RST_SETTLE(RST_SETTLE), .FORCE_IDX(FORCE_IDX)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .wr_addr(reg_wr_addr),
        .wr_data(reg_wr_data), .wr_allow(in_run), .div_sel(div_sel),
        .per_mask(per_mask), .settle(settle), .stop_cmd(stop_cmd)
    );

    pcm_divider #(
        .SEL_W(SEL_W), .MAX_LOG2(MAX_LOG2), .RST_SEL(RST_SEL)
    ) u_div (
        .clk(clk), .rst_n(rst_n), .hold(hold), .sel_req(div_sel), .tick(tick)
    );

    pcm_mode_fsm #(
        .SETTLE_W(SETTLE_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .stop_cmd(stop_cmd), .wait_req(wait_req),
        .irq_req(irq_req), .irq_en(irq_en), .gie(gie), .settle(settle),
        .state(state)
    );

    // Mode decode for gating and status.
    always_comb begin
        in_run      = (state == ST_RUN);
        in_wait     = (state == ST_WAIT);
        hold        = (state == ST_STOP) || (state == ST_WARM);
        osc_run     = (state != ST_STOP);
        mode_status = status_of(state);
        div_sel_o   = div_sel;
        cpu_clk_en  = tick && in_run;
        wdt_clk_en  = tick && in_run;
    end

    // One gate per peripheral group: runs in run, and in wait unless masked.
    for (genvar g = 0; g < NPER; g++) begin : g_per_gate
        always_comb per_clk_en[g] = tick && (in_run || (in_wait && !per_mask[g]));
    end

endmodule

// File: rtl/pcm_checker.sv
// Module: pcm_checker
// Temporal checks on the ports of pwr_clk_ctrl, attached through bind.
module pcm_checker #(
    parameter int ADDR_W    = 4,
    parameter int SEL_W     = 3,
    parameter int NPER      = 5,
    parameter int CTL_ADDR  = 7,
    parameter int FORCE_IDX = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr_en,
    input logic [ADDR_W-1:0] reg_wr_addr,
    input logic              wr_stop_bit,
    input logic              wait_req,
    input logic              irq_req,
    input logic              irq_en,
    input logic              cpu_clk_en,
    input logic              wdt_clk_en,
    input logic [NPER-1:0]   per_clk_en,
    input logic              osc_run,
    input logic [1:0]        mode_status,
    input logic [SEL_W-1:0]  div_sel_o
);

    logic past_ok;
    logic stop_wr;

    // Marks cycles whose previous cycle was already out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // Stop command as seen at the ports.
    always_comb stop_wr = reg_wr_en && (reg_wr_addr == ADDR_W'(CTL_ADDR)) && wr_stop_bit;

    AST_STATUS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        mode_status != 2'b11); // R1
    AST_EN_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_clk_en |-> (wdt_clk_en && (&per_clk_en))); // R2
    AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_status == 2'b10) |-> (!cpu_clk_en && !wdt_clk_en && (per_clk_en == '0))); // R4
    AST_STOP_FORCE_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_wr && mode_status == 2'b00) |=> (mode_status == 2'b10 && !osc_run && div_sel_o[FORCE_IDX])); // R5
    AST_STOP_WAKE_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(mode_status == 2'b10 && !osc_run) && osc_run) |-> $past(irq_req)); // R6
    AST_WARM_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_status == 2'b10 && osc_run) |=> (mode_status == 2'b10 || mode_status == 2'b00)); // R7
    AST_WAIT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_status == 2'b01) |-> (!cpu_clk_en && !wdt_clk_en)); // R8
    AST_WAIT_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(mode_status == 2'b01) && mode_status == 2'b00) |-> $past(irq_req && irq_en)); // R10
    AST_LOCKED_REGS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && mode_status != 2'b00) |=> $stable(div_sel_o)); // R11
    AST_STOP_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_wr && wait_req && mode_status == 2'b00) |=> (mode_status == 2'b10)); // R12

endmodule

bind pwr_clk_ctrl pcm_checker #(
    .ADDR_W(ADDR_W), .SEL_W(SEL_W), .NPER(NPER),
    .CTL_ADDR(CTL_ADDR), .FORCE_IDX(FORCE_IDX)
) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr),
    .wr_stop_bit(reg_wr_data[0]), .wait_req(wait_req), .irq_req(irq_req),
    .irq_en(irq_en), .cpu_clk_en(cpu_clk_en), .wdt_clk_en(wdt_clk_en),
    .per_clk_en(per_clk_en), .osc_run(osc_run), .mode_status(mode_status),
    .div_sel_o(div_sel_o)
);

// File: tb/pwr_clk_ctrl_tb.sv
// Testbench: sweeps divider selects, peripheral masks and wake-up cases;
// expected counts are computed arithmetically from the requirements.
module pwr_clk_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr_en = 1'b0;
    logic [3:0] reg_wr_addr = '0;
    logic [7:0] reg_wr_data = '0;
    logic       wait_req = 1'b0;
    logic       irq_req = 1'b0;
    logic       irq_en = 1'b0;
    logic       gie = 1'b0;
    logic       cpu_clk_en;
    logic       wdt_clk_en;
    logic [4:0] per_clk_en;
    logic       osc_run;
    logic [1:0] mode_status;
    logic [2:0] div_sel_o;

    int checks = 0;
    int errors = 0;
    int c_cpu, c_wdt;
    int c_per [5];

    always #2 clk = ~clk;

    pwr_clk_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr),
        .reg_wr_data(reg_wr_data), .wait_req(wait_req), .irq_req(irq_req),
        .irq_en(irq_en), .gie(gie), .cpu_clk_en(cpu_clk_en), .wdt_clk_en(wdt_clk_en),
        .per_clk_en(per_clk_en), .osc_run(osc_run), .mode_status(mode_status),
        .div_sel_o(div_sel_o)
    );

    function automatic int ratio(input int sel);
        return (sel >= 4) ? 16 : (1 << sel);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input int addr, input logic [7:0] data);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_addr = 4'(addr); reg_wr_data = data;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic pulse_wait();
        @(negedge clk); wait_req = 1'b1;
        @(negedge clk); wait_req = 1'b0;
    endtask

    task automatic pulse_irq();
        @(negedge clk); irq_req = 1'b1;
        @(negedge clk); irq_req = 1'b0;
    endtask

    task automatic count_en(input int n);
        c_cpu = 0; c_wdt = 0;
        for (int g = 0; g < 5; g++) c_per[g] = 0;
        repeat (n) begin
            @(negedge clk);
            c_cpu += int'(cpu_clk_en);
            c_wdt += int'(wdt_clk_en);
            for (int g = 0; g < 5; g++) c_per[g] += int'(per_clk_en[g]);
        end
    endtask

    // Pulse an interrupt from stop and count settling cycles (status 10, oscillator on).
    task automatic wake_and_count(output int warm, output int leak);
        @(negedge clk); irq_req = 1'b1;
        @(negedge clk); irq_req = 1'b0;
        warm = 0; leak = 0;
        for (int i = 0; i < 40; i++) begin
            if (mode_status == 2'b10 && osc_run) warm++;
            if (mode_status != 2'b00 && (cpu_clk_en || wdt_clk_en || per_clk_en != '0)) leak++;
            @(negedge clk);
        end
    endtask

    // Change select from a to b and check every interval between CPU pulses.
    task automatic interval_check(input int a, input int b);
        int last, bad, lastiv;
        wr(6, {3'(a), 5'b0});
        repeat (40) @(negedge clk);
        last = -1; bad = 0; lastiv = 0;
        for (int t = 0; t < 120; t++) begin
            @(negedge clk);
            if (t == 3) begin reg_wr_en = 1'b1; reg_wr_addr = 4'd6; reg_wr_data = {3'(b), 5'b0}; end
            if (t == 4) reg_wr_en = 1'b0;
            if (cpu_clk_en) begin
                if (last >= 0) begin
                    lastiv = t - last;
                    if (lastiv != ratio(a) && lastiv != ratio(b)) bad++;
                end
                last = t;
            end
        end
        chk(bad == 0, $sformatf("R3 intervals %0d->%0d", a, b), bad, 0);
        chk(lastiv == ratio(b), $sformatf("R3 final interval %0d->%0d", a, b), lastiv, ratio(b));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int warm, leak;
        do_reset();

        // Reset state.
        @(negedge clk);
        chk(mode_status == 2'b00, "R1 status", int'(mode_status), 0);
        chk(osc_run == 1'b1, "R1 osc_run", int'(osc_run), 1);
        chk(div_sel_o == 3'd3, "R1 div_sel", int'(div_sel_o), 3);
        count_en(64);
        chk(c_cpu == 8, "R1 divide by 8", c_cpu, 8);

        // Divider sweep over all select codes.
        for (int s = 0; s < 8; s++) begin
            wr(6, {3'(s), 5'b0});
            repeat (40) @(negedge clk);
            count_en(64);
            chk(c_cpu == 64 / ratio(s), $sformatf("R2 cpu sel=%0d", s), c_cpu, 64 / ratio(s));
            chk(c_wdt == 64 / ratio(s), $sformatf("R2 wdt sel=%0d", s), c_wdt, 64 / ratio(s));
            for (int g = 0; g < 5; g++)
                chk(c_per[g] == 64 / ratio(s), $sformatf("R2 per%0d sel=%0d", g, s), c_per[g], 64 / ratio(s));
        end

        // Boundary-aligned select changes.
        interval_check(4, 0);
        interval_check(0, 4);
        interval_check(3, 1);
        interval_check(1, 2);

        // Stop with settle 5 from select 1.
        irq_en = 1'b1; gie = 1'b1;
        wr(6, {3'd1, 5'b0});
        wr(7, {7'd5, 1'b0});
        wr(7, {7'd5, 1'b1});
        chk(mode_status == 2'b10, "R4 stop status", int'(mode_status), 2);
        chk(osc_run == 1'b0, "R4 osc halted", int'(osc_run), 0);
        chk(div_sel_o == 3'd3, "R5 forced select 1->3", int'(div_sel_o), 3);
        count_en(20);
        chk(c_cpu + c_wdt + c_per[0] + c_per[4] == 0, "R4 enables quiet", c_cpu + c_wdt, 0);
        wake_and_count(warm, leak);
        chk(warm == 5, "R7 settle 5", warm, 5);
        chk(leak == 0, "R7 no enable while settling", leak, 0);
        chk(mode_status == 2'b00, "R7 back to run", int'(mode_status), 0);
        count_en(64);
        chk(c_cpu == 8, "R5 forced ratio 8", c_cpu, 8);

        // Stop with settle 0 from select 0.
        wr(6, {3'd0, 5'b0});
        wr(7, {7'd0, 1'b1});
        chk(div_sel_o == 3'd2, "R5 forced select 0->2", int'(div_sel_o), 2);
        wake_and_count(warm, leak);
        chk(warm == 0, "R7 settle 0", warm, 0);
        count_en(64);
        chk(c_cpu == 16, "R5 forced ratio 4", c_cpu, 16);

        // Unqualified stop: global flag clear at entry, set afterwards.
        gie = 1'b0;
        wr(7, {7'd3, 1'b1});
        gie = 1'b1;
        pulse_irq();
        repeat (20) @(negedge clk);
        chk(mode_status == 2'b10 && !osc_run, "R6 gie captured at entry", int'(osc_run), 0);
        do_reset();
        @(negedge clk);
        chk(mode_status == 2'b00, "R6 reset ends stop", int'(mode_status), 0);

        // Unqualified stop: enable clear at entry.
        irq_en = 1'b0;
        wr(7, {7'd16, 1'b1});
        irq_en = 1'b1;
        pulse_irq();
        repeat (20) @(negedge clk);
        chk(mode_status == 2'b10 && !osc_run, "R6 enable captured at entry", int'(osc_run), 0);
        do_reset();

        // Default settle count after reset.
        irq_en = 1'b1; gie = 1'b1;
        wr(7, {7'd16, 1'b1});
        wake_and_count(warm, leak);
        chk(warm == 16, "R7 default settle 16", warm, 16);

        // Wait with all peripherals gated; writes during wait are ignored.
        wr(6, {3'd2, 5'b11111});
        irq_en = 1'b0;
        pulse_wait();
        chk(mode_status == 2'b01, "R8 wait status", int'(mode_status), 1);
        count_en(64);
        chk(c_cpu == 0 && c_wdt == 0, "R8 cpu and wdt gated", c_cpu + c_wdt, 0);
        chk(c_per[2] == 0, "R9 masked group gated", c_per[2], 0);
        wr(6, {3'd0, 5'b0});
        chk(div_sel_o == 3'd2, "R11 select write ignored in wait", int'(div_sel_o), 2);
        wr(7, {7'd1, 1'b1});
        chk(mode_status == 2'b01, "R11 stop write ignored in wait", int'(mode_status), 1);
        pulse_irq();
        repeat (4) @(negedge clk);
        chk(mode_status == 2'b01, "R10 disabled irq ignored", int'(mode_status), 1);
        irq_en = 1'b1;
        pulse_irq();
        chk(mode_status == 2'b00, "R10 wake from wait", int'(mode_status), 0);
        count_en(64);
        chk(c_cpu == 16, "R10 ratio kept across wait", c_cpu, 16);

        // Peripheral mask sweep in wait.
        for (int m = 0; m < 32; m++) begin
            wr(6, {3'd1, 5'(m)});
            pulse_wait();
            count_en(32);
            for (int g = 0; g < 5; g++) begin
                int e;
                e = ((m >> g) & 1) ? 0 : 16;
                chk(c_per[g] == e, $sformatf("R9 mask=%0d group=%0d", m, g), c_per[g], e);
            end
            pulse_irq();
        end

        // Stop beats wait in the same cycle.
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_addr = 4'd7; reg_wr_data = {7'd2, 1'b1}; wait_req = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0; wait_req = 1'b0;
        chk(mode_status == 2'b10 && !osc_run, "R12 stop wins over wait", int'(mode_status), 2);
        wake_and_count(warm, leak);
        chk(warm == 2, "R12 settle after priority stop", warm, 2);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule